// File: doc/BRIEF.md
# Interrupt Status Snapshot Register Set

This block holds the three registers that software reads as a group after a controller raises its interrupt: a status register, a sequence-step register and an interrupt-cause register. The command engine writes the live copies through dedicated update ports. Software reads them through a simple read port. Its intended order is status first, then sequence step, then interrupt cause.

The core may update the live registers between two of those reads. To keep that from producing a torn view, a status read taken while the interrupt-pending bit is set copies the interrupt-cause and sequence-step values into a private snapshot and zeroes the live cause register. Until the cause register is read, the sequence-step and cause reads return the snapshot. A non-zero saved cause marks the snapshot as valid. Reading the cause register releases the snapshot and performs the usual clear-on-read side effects. The interrupt request output is the live interrupt-pending status bit.

Top module: `intsnap_regset`

## Requirements
- R1: A read at address 0 (status) returns the live status. If status bit 7 (interrupt pending) is set at that read, the live cause and step values are saved at the same edge, and the live cause register becomes zero.
- R2: A status read with bit 7 clear saves nothing: the snapshot is left unchanged, and the following step read returns the live step value.
- R3: A read at address 1 (sequence step) returns the saved step value while the saved cause is non-zero, and the live step value otherwise. It has no side effect.
- R4: A read at address 2 (interrupt cause) while the saved cause is non-zero returns the saved cause and clears it. The live registers stay unchanged when the live cause is non-zero.
- R5: On such a read, if the live cause is zero, status bit 4 (terminal count) and status bit 7 are cleared, and the step register is loaded with the command-done code 4.
- R6: A cause read with no snapshot returns the live cause. It zeroes the live cause and the step register, and clears every status bit except bit 4.
- R7: A core update in the same cycle as a read is applied after the read's side effects and after the snapshot, so the snapshot keeps the pre-update values and the live register takes the core value.
- R8: Read data appears in the cycle after the read strobe. It is zero in any cycle without a read, and a read at address 3 returns zero.
- R9: The interrupt request output equals live status bit 7.
- R10: Reset zeroes all live and saved registers, the read data and the interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address: 0 status, 1 step, 2 cause, 3 unused |
| rd_data | output | DW | Registered read data |
| core_stat_we | input | 1 | Core write enable for live status |
| core_stat_d | input | DW | Core status value |
| core_seq_we | input | 1 | Core write enable for live step |
| core_seq_d | input | DW | Core step value |
| core_intr_we | input | 1 | Core write enable for live cause |
| core_intr_d | input | DW | Core cause value |
| irq | output | 1 | Interrupt request |

## Verification
Every read's data and all of its side effects land at the same clock edge. The data is therefore compared one cycle after the strobe, at the falling edge. The interrupt request follows the live status with no further delay, so it is compared at that same falling edge. A bench model advances its register image once per strobed cycle, using that cycle's reads and core writes with the core write applied last. This keeps every expected value aligned to the edge where the design changes. Directed sequences place core updates between the status read and the cause read, and cover both outcomes of the live-cause-zero test.

// File: rtl/intsnap_pkg.sv
package intsnap_pkg;
   typedef enum logic [1:0] {
      RA_STAT = 2'd0,
      RA_SEQ  = 2'd1,
      RA_INTR = 2'd2,
      RA_NONE = 2'd3
   } rd_addr_e;
endpackage

// File: rtl/intsnap_live.sv
// Live status, step and cause registers with read side effects and core updates.
module intsnap_live #(
   parameter int DW       = 8,
   parameter int INT_BIT  = 7,
   parameter int TC_BIT   = 4,
   parameter int SEQ_DONE = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          rd_intr,
   input  logic          snap_vld,
   input  logic          core_stat_we,
   input  logic [DW-1:0] core_stat_d,
   input  logic          core_seq_we,
   input  logic [DW-1:0] core_seq_d,
   input  logic          core_intr_we,
   input  logic [DW-1:0] core_intr_d,
   output logic [DW-1:0] stat_q,
   output logic [DW-1:0] seq_q,
   output logic [DW-1:0] intr_q
);
   localparam logic [DW-1:0] DONE_CODE = DW'(SEQ_DONE);

   logic          intr_zero;
   logic          rel_clear;
   logic          plain_clear;
   logic [DW-1:0] stat_n;
   logic [DW-1:0] seq_n;
   logic [DW-1:0] intr_n;

   assign intr_zero   = (intr_q == '0);
   assign rel_clear   = rd_intr && snap_vld && intr_zero;
   assign plain_clear = rd_intr && !snap_vld;

   for (genvar b = 0; b < DW; b++) begin : g_stat
      localparam bit KEEP_ON_PLAIN = (b == TC_BIT);
      localparam bit CLR_ON_REL    = (b == TC_BIT) || (b == INT_BIT);
      assign stat_n[b] = core_stat_we ? core_stat_d[b] :
                         (plain_clear && !KEEP_ON_PLAIN) ? 1'b0 :
                         (rel_clear && CLR_ON_REL) ? 1'b0 : stat_q[b];
   end

   always_comb begin
      seq_n = seq_q;
      if (rel_clear)        seq_n = DONE_CODE;
      else if (plain_clear) seq_n = '0;
      if (core_seq_we)      seq_n = core_seq_d;
   end

   always_comb begin
      intr_n = intr_q;
      if (take || plain_clear) intr_n = '0;
      if (core_intr_we)        intr_n = core_intr_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         seq_q  <= '0;
         intr_q <= '0;
      end else begin
         stat_q <= stat_n;
         seq_q  <= seq_n;
         intr_q <= intr_n;
      end
   end
endmodule

// File: rtl/intsnap_capture.sv
// Snapshot of cause and step taken on a status read with an interrupt pending.
module intsnap_capture #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          rd_intr,
   input  logic [DW-1:0] live_intr,
   input  logic [DW-1:0] live_seq,
   output logic [DW-1:0] sv_intr,
   output logic [DW-1:0] sv_seq,
   output logic          snap_vld
);
   assign snap_vld = (sv_intr != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sv_intr <= '0;
         sv_seq  <= '0;
      end else if (take) begin
         sv_intr <= live_intr;
         sv_seq  <= live_seq;
      end else if (rd_intr && snap_vld) begin
         sv_intr <= '0;
      end
   end
endmodule

// File: rtl/intsnap_rdmux.sv
// Read data selection and output register.
module intsnap_rdmux #(
   parameter int DW = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rd_en,
   input  intsnap_pkg::rd_addr_e rd_sel,
   input  logic                  snap_vld,
   input  logic [DW-1:0]         stat_q,
   input  logic [DW-1:0]         seq_q,
   input  logic [DW-1:0]         intr_q,
   input  logic [DW-1:0]         sv_seq,
   input  logic [DW-1:0]         sv_intr,
   output logic [DW-1:0]         rd_data
);
   import intsnap_pkg::*;

   logic [DW-1:0] sel_val;

   always_comb begin
      unique case (rd_sel)
         RA_STAT: sel_val = stat_q;
         RA_SEQ:  sel_val = snap_vld ? sv_seq : seq_q;
         RA_INTR: sel_val = snap_vld ? sv_intr : intr_q;
         default: sel_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= sel_val;
      else            rd_data <= '0;
   end
endmodule

// File: rtl/intsnap_regset.sv
// Top: interrupt status snapshot register set.
module intsnap_regset #(
   parameter int DW       = 8,
   parameter int INT_BIT  = 7,
   parameter int TC_BIT   = 4,
   parameter int SEQ_DONE = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic [1:0]    rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic          core_stat_we,
   input  logic [DW-1:0] core_stat_d,
   input  logic          core_seq_we,
   input  logic [DW-1:0] core_seq_d,
   input  logic          core_intr_we,
   input  logic [DW-1:0] core_intr_d,
   output logic          irq
);
   import intsnap_pkg::*;

   if (DW < 2) begin : g_bad_dw
      $error("intsnap_regset: DW must be at least 2");
   end
   if (INT_BIT < 0 || INT_BIT >= DW) begin : g_bad_int
      $error("intsnap_regset: INT_BIT outside status width");
   end
   if (TC_BIT < 0 || TC_BIT >= DW) begin : g_bad_tc
      $error("intsnap_regset: TC_BIT outside status width");
   end
   if (TC_BIT == INT_BIT) begin : g_bad_overlap
      $error("intsnap_regset: TC_BIT and INT_BIT must differ");
   end
   if (SEQ_DONE < 0 || SEQ_DONE >= (1 << DW)) begin : g_bad_done
      $error("intsnap_regset: SEQ_DONE does not fit in DW bits");
   end

   rd_addr_e      rd_sel;
   logic          rd_stat;
   logic          rd_intr;
   logic          take;
   logic          snap_vld;
   logic [DW-1:0] stat_q;
   logic [DW-1:0] seq_q;
   logic [DW-1:0] intr_q;
   logic [DW-1:0] sv_intr;
   logic [DW-1:0] sv_seq;

   assign rd_sel  = rd_addr_e'(rd_addr);
   assign rd_stat = rd_en && (rd_sel == RA_STAT);
   assign rd_intr = rd_en && (rd_sel == RA_INTR);
   assign take    = rd_stat && stat_q[INT_BIT];
   assign irq     = stat_q[INT_BIT];

   intsnap_live #(
      .DW(DW), .INT_BIT(INT_BIT), .TC_BIT(TC_BIT), .SEQ_DONE(SEQ_DONE)
   ) u_live (
      .clk          (clk),
      .rst_n        (rst_n),
      .take         (take),
      .rd_intr      (rd_intr),
      .snap_vld     (snap_vld),
      .core_stat_we (core_stat_we),
      .core_stat_d  (core_stat_d),
      .core_seq_we  (core_seq_we),
      .core_seq_d   (core_seq_d),
      .core_intr_we (core_intr_we),
      .core_intr_d  (core_intr_d),
      .stat_q       (stat_q),
      .seq_q        (seq_q),
      .intr_q       (intr_q)
   );

   intsnap_capture #(.DW(DW)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .rd_intr   (rd_intr),
      .live_intr (intr_q),
      .live_seq  (seq_q),
      .sv_intr   (sv_intr),
      .sv_seq    (sv_seq),
      .snap_vld  (snap_vld)
   );

   intsnap_rdmux #(.DW(DW)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .rd_sel   (rd_sel),
      .snap_vld (snap_vld),
      .stat_q   (stat_q),
      .seq_q    (seq_q),
      .intr_q   (intr_q),
      .sv_seq   (sv_seq),
      .sv_intr  (sv_intr),
      .rd_data  (rd_data)
   );
endmodule

// File: rtl/intsnap_regset_chk.sv
// Property checker for intsnap_regset, attached by bind.
module intsnap_regset_chk #(
   parameter int DW       = 8,
   parameter int INT_BIT  = 7,
   parameter int TC_BIT   = 4,
   parameter int SEQ_DONE = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_en,
   input logic [1:0]    rd_addr,
   input logic [DW-1:0] rd_data,
   input logic          irq,
   input logic          core_stat_we,
   input logic          core_seq_we,
   input logic [DW-1:0] stat_q,
   input logic [DW-1:0] seq_q,
   input logic [DW-1:0] intr_q,
   input logic [DW-1:0] sv_intr,
   input logic [DW-1:0] sv_seq,
   input logic          snap_vld
);
   localparam logic [DW-1:0] TC_ONLY = DW'(1) << TC_BIT;

   AST_CAPTURE_ON_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == 2'd0 && stat_q[INT_BIT]) |=>
         (sv_intr == $past(intr_q) && sv_seq == $past(seq_q))) else $error("capture"); // R1

   AST_NO_CAPTURE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == 2'd0 && !stat_q[INT_BIT]) |=>
         ($stable(sv_intr) && $stable(sv_seq))) else $error("no capture"); // R2

   AST_SEQ_FROM_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == 2'd1 && snap_vld) |=> (rd_data == $past(sv_seq)))
      else $error("seq snapshot"); // R3

   AST_RELEASE_ON_INTR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == 2'd2 && snap_vld) |=> (sv_intr == '0))
      else $error("release"); // R4

   AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == 2'd2 && snap_vld && intr_q == '0 && !core_stat_we) |=> !irq)
      else $error("irq drop"); // R5

   AST_DONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == 2'd2 && snap_vld && intr_q == '0 && !core_seq_we) |=>
         (seq_q == DW'(SEQ_DONE))) else $error("done code"); // R5

   AST_PLAIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == 2'd2 && !snap_vld && !core_stat_we) |=>
         ((stat_q & ~TC_ONLY) == '0)) else $error("plain clear"); // R6

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rd_data == '0)) else $error("idle data"); // R8
endmodule

bind intsnap_regset intsnap_regset_chk #(
   .DW(DW), .INT_BIT(INT_BIT), .TC_BIT(TC_BIT), .SEQ_DONE(SEQ_DONE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rd_en        (rd_en),
   .rd_addr      (rd_addr),
   .rd_data      (rd_data),
   .irq          (irq),
   .core_stat_we (core_stat_we),
   .core_seq_we  (core_seq_we),
   .stat_q       (stat_q),
   .seq_q        (seq_q),
   .intr_q       (intr_q),
   .sv_intr      (sv_intr),
   .sv_seq       (sv_seq),
   .snap_vld     (snap_vld)
);

// File: tb/intsnap_regset_tb.sv
module intsnap_regset_tb;
   localparam int DW = 8;
   localparam int INT_BIT = 7;
   localparam int TC_BIT = 4;
   localparam logic [DW-1:0] DONE = 8'd4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_en = 1'b0;
   logic [1:0]    rd_addr = 2'd0;
   logic [DW-1:0] rd_data;
   logic          core_stat_we = 1'b0, core_seq_we = 1'b0, core_intr_we = 1'b0;
   logic [DW-1:0] core_stat_d = '0, core_seq_d = '0, core_intr_d = '0;
   logic          irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench register image
   logic [DW-1:0] m_stat = '0, m_seq = '0, m_intr = '0, m_svi = '0, m_svs = '0;
   logic [DW-1:0] exp_rd = '0;

   always #2 clk = ~clk;

   intsnap_regset u_dut (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .core_stat_we(core_stat_we), .core_stat_d(core_stat_d),
      .core_seq_we(core_seq_we), .core_seq_d(core_seq_d),
      .core_intr_we(core_intr_we), .core_intr_d(core_intr_d), .irq(irq)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
      end
   endtask

   // Expected read data from requirements R1, R3, R4, R6, R8
   function automatic logic [DW-1:0] exp_read(input logic en, input logic [1:0] a);
      if (!en) return '0;
      case (a)
         2'd0: return m_stat;
         2'd1: return (m_svi != '0) ? m_svs : m_seq;
         2'd2: return (m_svi != '0) ? m_svi : m_intr;
         default: return '0;
      endcase
   endfunction

   // Advance image: read side effects first, core writes last (R7)
   task automatic model_step(input logic en, input logic [1:0] a);
      logic [DW-1:0] ns = m_stat, nq = m_seq, ni = m_intr, nsvi = m_svi, nsvs = m_svs;
      if (en && a == 2'd0 && m_stat[INT_BIT]) begin
         nsvi = m_intr; nsvs = m_seq; ni = '0;
      end else if (en && a == 2'd2) begin
         if (m_svi != '0) begin
            nsvi = '0;
            if (m_intr == '0) begin
               ns[TC_BIT] = 1'b0; ns[INT_BIT] = 1'b0; nq = DONE;
            end
         end else begin
            ni = '0; nq = '0; ns = m_stat & (8'd1 << TC_BIT);
         end
      end
      if (core_stat_we) ns = core_stat_d;
      if (core_seq_we)  nq = core_seq_d;
      if (core_intr_we) ni = core_intr_d;
      m_stat = ns; m_seq = nq; m_intr = ni; m_svi = nsvi; m_svs = nsvs;
   endtask

   task automatic cyc(input logic en, input logic [1:0] a, input string tag,
                      input logic sw, input logic [DW-1:0] sd,
                      input logic qw, input logic [DW-1:0] qd,
                      input logic iw, input logic [DW-1:0] id);
      string t;
      rd_en = en; rd_addr = a;
      core_stat_we = sw; core_stat_d = sd;
      core_seq_we = qw;  core_seq_d = qd;
      core_intr_we = iw; core_intr_d = id;
      exp_rd = exp_read(en, a);
      model_step(en, a);
      if (tag != "") t = tag;
      else if (!en || a == 2'd3) t = "R8";
      else if (a == 2'd0) t = "R1";
      else if (a == 2'd1) t = "R3";
      else t = "R4/R6";
      @(posedge clk);
      @(negedge clk);
      check(t, rd_data, exp_rd);
      check("R9 irq", {7'd0, irq}, {7'd0, m_stat[INT_BIT]});
   endtask

   task automatic rd(input logic [1:0] a, input string tag);
      cyc(1'b1, a, tag, 1'b0, '0, 1'b0, '0, 1'b0, '0);
   endtask

   task automatic load(input logic [DW-1:0] s, input logic [DW-1:0] q, input logic [DW-1:0] i);
      cyc(1'b0, 2'd0, "R8", 1'b1, s, 1'b1, q, 1'b1, i);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 rd_data", rd_data, '0);
      check("R10 irq", {7'd0, irq}, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(2'd1, "R10 step");
      rd(2'd2, "R10 cause");
      rd(2'd0, "R10 status");

      // R7 race: core updates during status read, snapshot keeps old values
      load(8'h90, 8'h03, 8'h18);
      cyc(1'b1, 2'd0, "R7 status", 1'b1, 8'h90, 1'b1, 8'h05, 1'b1, 8'h20);
      rd(2'd1, "R3 saved step");
      rd(2'd2, "R4 saved cause");
      rd(2'd0, "R4 status kept");
      rd(2'd2, "R6 live cause");
      rd(2'd0, "R6 status cleared");
      rd(2'd1, "R6 step cleared");

      // R5: release with live cause zero
      load(8'h90, 8'h02, 8'h08);
      rd(2'd0, "R1 status");
      rd(2'd2, "R1 live cause zeroed");
      load(8'h90, 8'h02, 8'h08);
      rd(2'd0, "R1 capture");
      rd(2'd1, "R3 step");
      rd(2'd2, "R5 cause");
      rd(2'd0, "R5 status");
      rd(2'd1, "R5 done code");

      // R2: no interrupt pending, no capture
      load(8'h10, 8'h01, 8'h08);
      rd(2'd0, "R2 status");
      rd(2'd1, "R2 live step");
      rd(2'd3, "R8 unused address");
      cyc(1'b0, 2'd1, "R8 idle", 1'b0, '0, 1'b0, '0, 1'b0, '0);

      // constrained random traffic
      for (int k = 0; k < 4000; k++) begin
         logic en, sw, qw, iw;
         logic [1:0] a;
         logic [DW-1:0] sd, qd, id;
         en = ($urandom % 4) != 0;
         a  = 2'($urandom % 4);
         if (($urandom % 3) != 0) a = 2'($urandom % 3);
         sw = ($urandom % 6) == 0;
         qw = ($urandom % 6) == 0;
         iw = ($urandom % 6) == 0;
         sd = 8'($urandom);
         if (($urandom % 2) == 0) sd[INT_BIT] = 1'b1;
         qd = 8'($urandom % 8);
         id = (($urandom % 4) == 0) ? 8'd0 : 8'($urandom);
         cyc(en, a, "", sw, sd, qw, qd, iw, id);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule